// File: doc/BRIEF.md
# Icount fetch thread selector

This block decides which hardware thread of a simultaneous multithreaded front end gets the fetch slot in each cycle. For every thread it tracks how many instructions are in flight. The count rises by one each time the thread is granted a fetch. It falls by one on a retire and by a given amount on a squash. The grant goes to the eligible thread that holds the fewest in-flight instructions, so threads that drain quickly get more fetch bandwidth and a stalled thread cannot clog the shared queues.

A thread that spins on a lock can park itself. It first registers a watch on one address. It then issues a quiesce request, which puts it to sleep. The snooped write stream is compared against every armed watch. A write to the watched address wakes the thread, and it becomes eligible again in the following cycle. A thread is also held back when its count reaches a cap. The cap is the full queue depth when only one thread is enabled, and a smaller shared cap when two or more threads are enabled.

Top module: `icount_fetch_sel`

## Requirements
- R1: After reset, every in-flight count is 0 and no thread is asleep. With all threads enabled, the first grant goes to thread 0.
- R2: `fetch_tid` is the enabled, awake, below-cap thread with the smallest in-flight count. Disabled threads are never granted.
- R3: When several eligible threads share the minimum count, the one with the lowest thread number is granted.
- R4: A thread's count rises by exactly 1 in the cycle after it is granted. It falls by 1 in the cycle after its `retire_vec` bit is set. A grant and a retire in the same cycle leave the count unchanged.
- R5: A squash subtracts the thread's `squash_amt` field (bits `[i*CNT_W +: CNT_W]`) in one cycle, together with any retire. The count saturates at 0 and never wraps.
- R6: With two or more bits of `thread_en` set, a thread whose count is at least QUEUE_DEPTH-RESERVE is not granted. With one bit set, the thread may fill up to QUEUE_DEPTH. No count ever exceeds QUEUE_DEPTH.
- R7: A quiesce request from an armed thread makes `asleep` for that thread 1 from the next cycle. A sleeping thread is never granted, and its count does not grow.
- R8: A snooped write whose address equals the sleeping thread's watched address clears its `asleep` bit on the next cycle. A write to any other address leaves it asleep.
- R9: A matching write that arrives after arming but before the quiesce cancels the watch, so the later quiesce has no effect. A quiesce from a thread that never armed also has no effect.
- R10: When no thread is eligible, `fetch_valid` is 0 and `fetch_tid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_en | input | NTHREADS | Thread is enabled for fetch |
| retire_vec | input | NTHREADS | One instruction of the thread retired |
| squash_vec | input | NTHREADS | Thread squashes `squash_amt` entries |
| squash_amt | input | NTHREADS*CNT_W | Per-thread squash amount, thread i at `[i*CNT_W +: CNT_W]` |
| arm_valid | input | 1 | Arm a watch for `arm_tid` |
| arm_tid | input | TID_W | Thread arming a watch |
| arm_addr | input | ADDR_W | Address to watch |
| quiesce_vec | input | NTHREADS | Thread requests sleep on its armed watch |
| snoop_valid | input | 1 | A write is observed |
| snoop_addr | input | ADDR_W | Address of the observed write |
| fetch_valid | output | 1 | A thread is granted this cycle |
| fetch_tid | output | TID_W | Granted thread |
| inflight | output | NTHREADS*CNT_W | Per-thread in-flight counts |
| asleep | output | NTHREADS | Thread is quiesced |

## Verification
A corrupted in-flight count shows up in `inflight` one cycle after the update that caused it. It also shows up in `fetch_tid` in that same cycle whenever it changes the minimum, so the grant order over a few cycles exposes it. A watch that holds the wrong address or state shows up as an `asleep` bit that does not rise after a quiesce, does not fall on the matching write, or falls on a wrong write. The bench probes each of these one cycle after the stimulus. A broken cap becomes visible as `fetch_valid` staying high beyond the expected fill level.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

   function automatic int cnt_bits(input int depth);
      return $clog2(depth + 1);
   endfunction

   function automatic int tid_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   typedef enum logic [1:0] {
      WATCH_IDLE   = 2'd0,
      WATCH_ARMED  = 2'd1,
      WATCH_ASLEEP = 2'd2
   } watch_state_e;

endpackage

// File: rtl/ifs_inflight_ctr.sv
module ifs_inflight_ctr #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   input  logic             sq_en,
   input  logic [CNT_W-1:0] sq_amt,
   output logic [CNT_W-1:0] cnt
);
   localparam int WW = CNT_W + 1;

   logic [WW-1:0] up, down, nxt;

   always_comb begin
      up   = {1'b0, cnt} + WW'(inc);
      down = WW'(dec) + (sq_en ? {1'b0, sq_amt} : '0);
      nxt  = (up > down) ? (up - down) : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= nxt[CNT_W-1:0];
   end
endmodule

// File: rtl/ifs_watch.sv
module ifs_watch #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic [ADDR_W-1:0] arm_addr,
   input  logic              quiesce,
   input  logic              snoop_valid,
   input  logic [ADDR_W-1:0] snoop_addr,
   output logic              asleep
);
   import ifs_pkg::*;

   watch_state_e      state;
   logic [ADDR_W-1:0] addr_q;
   logic              hit;

   assign hit    = snoop_valid && (state != WATCH_IDLE) && (snoop_addr == addr_q);
   assign asleep = (state == WATCH_ASLEEP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= WATCH_IDLE;
         addr_q <= '0;
      end else if (arm) begin
         state  <= WATCH_ARMED;
         addr_q <= arm_addr;
      end else if (hit) begin
         state  <= WATCH_IDLE;
      end else if (quiesce && state == WATCH_ARMED) begin
         state  <= WATCH_ASLEEP;
      end
   end
endmodule

// File: rtl/ifs_pick.sv
module ifs_pick #(
   parameter int NTHREADS = 4,
   parameter int CNT_W    = 4,
   parameter int TID_W    = 2
) (
   input  logic [NTHREADS-1:0]       elig,
   input  logic [NTHREADS*CNT_W-1:0] cnt_flat,
   output logic                      valid,
   output logic [TID_W-1:0]          tid
);
   logic [CNT_W-1:0] best;

   always_comb begin
      valid = 1'b0;
      tid   = '0;
      best  = '0;
      for (int i = 0; i < NTHREADS; i++) begin
         if (elig[i] && (!valid || cnt_flat[i*CNT_W +: CNT_W] < best)) begin
            valid = 1'b1;
            tid   = TID_W'(i);
            best  = cnt_flat[i*CNT_W +: CNT_W];
         end
      end
   end
endmodule

// File: rtl/icount_fetch_sel.sv
module icount_fetch_sel #(
   parameter int NTHREADS    = 4,
   parameter int QUEUE_DEPTH = 8,
   parameter int RESERVE     = 2,
   parameter int ADDR_W      = 16,
   localparam int CNT_W      = ifs_pkg::cnt_bits(QUEUE_DEPTH),
   localparam int TID_W      = ifs_pkg::tid_bits(NTHREADS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NTHREADS-1:0]       thread_en,
   input  logic [NTHREADS-1:0]       retire_vec,
   input  logic [NTHREADS-1:0]       squash_vec,
   input  logic [NTHREADS*CNT_W-1:0] squash_amt,
   input  logic                      arm_valid,
   input  logic [TID_W-1:0]          arm_tid,
   input  logic [ADDR_W-1:0]         arm_addr,
   input  logic [NTHREADS-1:0]       quiesce_vec,
   input  logic                      snoop_valid,
   input  logic [ADDR_W-1:0]         snoop_addr,
   output logic                      fetch_valid,
   output logic [TID_W-1:0]          fetch_tid,
   output logic [NTHREADS*CNT_W-1:0] inflight,
   output logic [NTHREADS-1:0]       asleep
);
   localparam int SHARE_CAP = QUEUE_DEPTH - RESERVE;

   initial begin
      assert (NTHREADS >= 2) else $error("NTHREADS must be at least 2");
      assert (QUEUE_DEPTH > RESERVE) else $error("RESERVE must be below QUEUE_DEPTH");
      assert (RESERVE >= 0) else $error("RESERVE must not be negative");
   end

   logic [CNT_W-1:0]    limit;
   logic [NTHREADS-1:0] elig;
   logic [NTHREADS-1:0] grant;

   generate
      if (RESERVE == 0) begin : g_nocap
         assign limit = CNT_W'(QUEUE_DEPTH);
      end else begin : g_cap
         logic shared;
         assign shared = ($countones(thread_en) > 1);
         assign limit  = shared ? CNT_W'(SHARE_CAP) : CNT_W'(QUEUE_DEPTH);
      end
   endgenerate

   for (genvar i = 0; i < NTHREADS; i++) begin : g_thr
      localparam logic [TID_W-1:0] MY_ID = TID_W'(i);

      assign grant[i] = fetch_valid && (fetch_tid == MY_ID);
      assign elig[i]  = thread_en[i] && !asleep[i] &&
                        (inflight[i*CNT_W +: CNT_W] < limit);

      ifs_inflight_ctr #(.CNT_W(CNT_W)) u_ctr (
         .clk    (clk),
         .rst_n  (rst_n),
         .inc    (grant[i]),
         .dec    (retire_vec[i]),
         .sq_en  (squash_vec[i]),
         .sq_amt (squash_amt[i*CNT_W +: CNT_W]),
         .cnt    (inflight[i*CNT_W +: CNT_W])
      );

      ifs_watch #(.ADDR_W(ADDR_W)) u_watch (
         .clk         (clk),
         .rst_n       (rst_n),
         .arm         (arm_valid && (arm_tid == MY_ID)),
         .arm_addr    (arm_addr),
         .quiesce     (quiesce_vec[i]),
         .snoop_valid (snoop_valid),
         .snoop_addr  (snoop_addr),
         .asleep      (asleep[i])
      );
   end

   ifs_pick #(.NTHREADS(NTHREADS), .CNT_W(CNT_W), .TID_W(TID_W)) u_pick (
      .elig     (elig),
      .cnt_flat (inflight),
      .valid    (fetch_valid),
      .tid      (fetch_tid)
   );
endmodule

// File: rtl/ifs_checker.sv
module ifs_checker #(
   parameter int NTHREADS    = 4,
   parameter int QUEUE_DEPTH = 8,
   parameter int CNT_W       = 4,
   parameter int TID_W       = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NTHREADS-1:0]       thread_en,
   input logic [NTHREADS-1:0]       quiesce_vec,
   input logic                      arm_valid,
   input logic [TID_W-1:0]          arm_tid,
   input logic                      snoop_valid,
   input logic                      fetch_valid,
   input logic [TID_W-1:0]          fetch_tid,
   input logic [NTHREADS*CNT_W-1:0] inflight,
   input logic [NTHREADS-1:0]       asleep
);
   assert_grant_eligible_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid |-> (thread_en[fetch_tid] && !asleep[fetch_tid]));

   for (genvar i = 0; i < NTHREADS; i++) begin : g_chk
      localparam logic [TID_W-1:0] MY_ID = TID_W'(i);

      assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
         inflight[i*CNT_W +: CNT_W] <= CNT_W'(QUEUE_DEPTH));

      assert_rise_by_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (inflight[i*CNT_W +: CNT_W] > $past(inflight[i*CNT_W +: CNT_W])) |->
            ($past(fetch_valid && fetch_tid == MY_ID) &&
             inflight[i*CNT_W +: CNT_W] == $past(inflight[i*CNT_W +: CNT_W]) + 1'b1));

      assert_sleep_from_quiesce_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(asleep[i]) |-> $past(quiesce_vec[i]));

      assert_wake_from_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(asleep[i]) |-> ($past(snoop_valid) || $past(arm_valid && arm_tid == MY_ID)));
   end
endmodule

bind icount_fetch_sel ifs_checker #(
   .NTHREADS(NTHREADS), .QUEUE_DEPTH(QUEUE_DEPTH), .CNT_W(CNT_W), .TID_W(TID_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .thread_en   (thread_en),
   .quiesce_vec (quiesce_vec),
   .arm_valid   (arm_valid),
   .arm_tid     (arm_tid),
   .snoop_valid (snoop_valid),
   .fetch_valid (fetch_valid),
   .fetch_tid   (fetch_tid),
   .inflight    (inflight),
   .asleep      (asleep)
);

// File: tb/icount_fetch_sel_test.sv
module icount_fetch_sel_test;
   localparam int N  = 4;
   localparam int QD = 8;
   localparam int CW = 4;
   localparam int TW = 2;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  thread_en = '0, retire_vec = '0, squash_vec = '0, quiesce_vec = '0;
   logic [N*CW-1:0] squash_amt = '0;
   logic          arm_valid = 1'b0, snoop_valid = 1'b0;
   logic [TW-1:0] arm_tid = '0;
   logic [AW-1:0] arm_addr = '0, snoop_addr = '0;
   logic          fetch_valid;
   logic [TW-1:0] fetch_tid;
   logic [N*CW-1:0] inflight;
   logic [N-1:0]  asleep;

   int vectors = 0;
   int misses  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   icount_fetch_sel #(.NTHREADS(N), .QUEUE_DEPTH(QD), .RESERVE(2), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .thread_en(thread_en), .retire_vec(retire_vec),
      .squash_vec(squash_vec), .squash_amt(squash_amt), .arm_valid(arm_valid),
      .arm_tid(arm_tid), .arm_addr(arm_addr), .quiesce_vec(quiesce_vec),
      .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .fetch_valid(fetch_valid),
      .fetch_tid(fetch_tid), .inflight(inflight), .asleep(asleep)
   );

   function automatic int cnt_of(input int t);
      return int'(inflight[t*CW +: CW]);
   endfunction

   task automatic check(input string tag, input int actual, input int expected);
      vectors++;
      if (actual != expected) begin
         misses++;
         $display("FAIL %s actual %0d expected %0d", tag, actual, expected);
      end
   endtask

   task automatic cyc(input int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic clear_pulses();
      retire_vec = '0; squash_vec = '0; squash_amt = '0; quiesce_vec = '0;
      arm_valid = 1'b0; snoop_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      thread_en = '0;
      clear_pulses();
      cyc(2);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      check("R10 idle valid", int'(fetch_valid), 0);
      check("R10 idle tid", int'(fetch_tid), 0);
      for (int t = 0; t < N; t++) check("R1 count zero", cnt_of(t), 0);
      check("R1 none asleep", int'(asleep), 0);
      thread_en = '1;
      #1;
      check("R1 first grant valid", int'(fetch_valid), 1);
      check("R1 first grant tid", int'(fetch_tid), 0);
   endtask

   task automatic t_rotation();
      do_reset();
      thread_en = '1;
      for (int k = 0; k < 8; k++) begin
         #1;
         check("R3 equal counts pick lowest", int'(fetch_tid), k % N);
         cyc();
      end
      for (int t = 0; t < N; t++) check("R4 grant increments", cnt_of(t), 2);
   endtask

   task automatic t_retire();
      do_reset();
      thread_en = '1;
      cyc(4);
      thread_en = '0;
      retire_vec = 4'b0100;
      cyc();
      clear_pulses();
      check("R4 retire decrements", cnt_of(2), 0);
      check("R4 other untouched", cnt_of(1), 1);
      thread_en = '1;
      #1;
      check("R2 pick smallest count", int'(fetch_tid), 2);
      thread_en = 4'b0100;
      retire_vec = 4'b0100;
      cyc();
      clear_pulses();
      thread_en = '0;
      check("R4 grant plus retire holds", cnt_of(2), 0);
      thread_en = 4'b1010;
      #1;
      check("R2 disabled threads skipped", int'(fetch_tid), 1);
   endtask

   task automatic t_squash();
      do_reset();
      thread_en = '1;
      cyc(8);
      thread_en = '0;
      squash_vec = 4'b1011;
      squash_amt[0*CW +: CW] = 4'd1;
      squash_amt[1*CW +: CW] = 4'd7;
      squash_amt[3*CW +: CW] = 4'd1;
      retire_vec = 4'b1000;
      cyc();
      clear_pulses();
      check("R5 squash subtracts", cnt_of(0), 1);
      check("R5 squash clamps at zero", cnt_of(1), 0);
      check("R5 squash plus retire", cnt_of(3), 0);
      check("R5 unsquashed thread", cnt_of(2), 2);
   endtask

   task automatic t_cap();
      do_reset();
      thread_en = 4'b0001;
      cyc(10);
      check("R6 single thread fills depth", cnt_of(0), QD);
      #1;
      check("R10 full single thread idle", int'(fetch_valid), 0);
      thread_en = 4'b0011;
      cyc(9);
      check("R6 shared cap", cnt_of(1), QD - 2);
      check("R6 full thread not granted", cnt_of(0), QD);
      #1;
      check("R10 all capped idle", int'(fetch_valid), 0);
      thread_en = 4'b0010;
      #1;
      check("R6 single thread cap lifts", int'(fetch_valid), 1);
      check("R6 single thread cap lifts tid", int'(fetch_tid), 1);
   endtask

   task automatic t_sleep();
      do_reset();
      arm_valid = 1'b1; arm_tid = 2'd1; arm_addr = 16'h1234;
      cyc();
      clear_pulses();
      check("R7 arm alone does not sleep", int'(asleep[1]), 0);
      quiesce_vec = 4'b0010;
      cyc();
      clear_pulses();
      check("R7 quiesce sleeps", int'(asleep[1]), 1);
      thread_en = 4'b0010;
      cyc(3);
      check("R7 sleeping thread not fetched", cnt_of(1), 0);
      #1;
      check("R7 sleeping thread idle", int'(fetch_valid), 0);
      snoop_valid = 1'b1; snoop_addr = 16'h1235;
      cyc();
      clear_pulses();
      check("R8 other address ignored", int'(asleep[1]), 1);
      snoop_valid = 1'b1; snoop_addr = 16'h1234;
      cyc();
      clear_pulses();
      check("R8 matching write wakes", int'(asleep[1]), 0);
      #1;
      check("R8 woken thread fetched", int'(fetch_valid), 1);
      check("R8 woken thread tid", int'(fetch_tid), 1);
   endtask

   task automatic t_early_write();
      do_reset();
      arm_valid = 1'b1; arm_tid = 2'd2; arm_addr = 16'h00AA;
      cyc();
      clear_pulses();
      snoop_valid = 1'b1; snoop_addr = 16'h00AA;
      cyc();
      clear_pulses();
      quiesce_vec = 4'b0100;
      cyc();
      clear_pulses();
      check("R9 early write cancels quiesce", int'(asleep[2]), 0);
      quiesce_vec = 4'b1000;
      cyc();
      clear_pulses();
      check("R9 quiesce without arm", int'(asleep[3]), 0);
      thread_en = 4'b1100;
      #1;
      check("R9 thread still eligible", int'(fetch_tid), 2);
   endtask

   initial begin
      t_reset();
      t_rotation();
      t_retire();
      t_squash();
      t_cap();
      t_sleep();
      t_early_write();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1'b1;
         misses++;
         $display("FAIL watchdog: run did not complete");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end
endmodule